// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This controller sits beside a simple in-order core and decides when one of eight level-sensitive device lines becomes a vectored handler entry. Line `s` carries urgency `s`, and 7 is the most urgent. An entry is only allowed at an instruction boundary, so work already in flight is never disturbed. When the controller accepts an entry it pushes the resume PC, the current priority level and the current mode onto a four-deep hardware stack. It then switches the core to supervisor mode and clears the global enable. The jump target is the base address plus four times the source index.

The handler software raises the priority level to mask its own source and every source below it, then sets the enable again. From that point a more urgent line can preempt the handler, and entries nest up to the stack depth. A return command pops the stack. It restores the previous level and mode, gives the resume PC on `epc_o` and leaves interrupts enabled, as they were in the interrupted context. A line stays pending for as long as the device holds it high, until software clears the device.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the controller is in user mode (`sup_o`=0) with `ie_o`=1, `level_o`=0, `depth_o`=0, `ovf_o`=0 and `take_o`=0.
- R2: `take_o` is high in a cycle if and only if `boundary_i`=1, `ie_o`=1, `rte_i`=0, `depth_o`<4 and at least one line `s` with `s >= level_o` is high. The decision is combinational in that same cycle.
- R3: When several eligible lines are high, `src_o` is the highest eligible index.
- R4: `vec_o` equals 0x100 + 4*`src_o`.
- R5: At the clock edge that ends a cycle with `take_o`=1, the controller pushes {`pc_i`, level, mode}. Afterwards `sup_o`=1, `ie_o`=0, the level is unchanged, `depth_o` has risen by one and `epc_o` shows the saved PC.
- R6: A line whose index is below `level_o` is never taken. A level of 8 masks every line.
- R7: A handler that has raised the level and re-enabled interrupts is preempted by a more urgent line, and this nests a second entry.
- R8: A return (`rte_i`=1 with `depth_o`>0) shows the top saved PC on `epc_o` in that cycle. At the edge it restores the saved level and mode, sets `ie_o`=1 and lowers `depth_o` by one. A return with an empty stack changes nothing.
- R9: If an otherwise eligible entry meets a full stack (`depth_o`=4), it is not taken and the state is left as it was. `ovf_o` goes to 1 and stays there until reset.
- R10: Writes to the level (`set_level_i`) and to the enable (`set_ie_i`) take effect only in supervisor mode. In user mode they are ignored.
- R11: When a return and an eligible entry fall in the same cycle, the return is performed and the entry is not taken. An entry or a return overrides a software write in the same cycle.
- R12: No entry is taken while `boundary_i`=0.
- R13: A line that is still held high after the return is taken again at the next eligible boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Level-sensitive device lines, index = urgency |
| boundary_i | input | 1 | Core is between instructions |
| pc_i | input | 32 | Resume PC to save on entry |
| rte_i | input | 1 | Return-from-exception command |
| set_level_i | input | 1 | Software write strobe for the priority level |
| level_wr_i | input | 4 | New priority level |
| set_ie_i | input | 1 | Software write strobe for the global enable |
| ie_wr_i | input | 1 | New global enable value |
| take_o | output | 1 | Entry is taken this cycle |
| src_o | output | 3 | Source being taken |
| vec_o | output | 32 | Vector address of the entry |
| epc_o | output | 32 | Saved PC at the top of the stack |
| level_o | output | 4 | Current priority level |
| ie_o | output | 1 | Global interrupt enable |
| sup_o | output | 1 | Supervisor mode |
| depth_o | output | 3 | Nesting depth |
| ovf_o | output | 1 | Sticky nesting overflow flag |

## Verification
The case most likely to go wrong is a cycle where a return and a new entry happen together. A handler sits at depth two with the level lowered to 6. Line 7 is then raised at a boundary in the same cycle that `rte_i` is asserted. The check expects `take_o` to stay low in that cycle, and after the edge it expects the popped level, the depth reduced by one and the enable set. On the next boundary the same line must then be taken normally. A software write is also issued in the same cycle as an entry, and the check expects the entry's values to win.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic {MODE_USER = 1'b0, MODE_SUP = 1'b1} mode_e;
  localparam int unsigned DEF_N_SRC   = 8;
  localparam int unsigned DEF_DEPTH   = 4;
  localparam int unsigned DEF_PC_W    = 32;
  localparam logic [31:0] DEF_VEC_BASE = 32'h0000_0100;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned SRC_W = $clog2(N_SRC),
  parameter int unsigned LVL_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             valid_o,
  output logic [SRC_W-1:0] idx_o
);
  logic [N_SRC-1:0] elig;

  for (genvar s = 0; s < N_SRC; s++) begin : g_elig
    assign elig[s] = req_i[s] && (LVL_W'(s) >= level_i);
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (elig[s]) begin
        valid_o = 1'b1;
        idx_o   = SRC_W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int unsigned W     = 37,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DEP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     dout_o,
  output logic [DEP_W-1:0] depth_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [DEP_W-1:0] depth_q;
  logic [DEP_W-1:0] top_ptr;

  assign full_o  = (depth_q == DEP_W'(DEPTH));
  assign empty_o = (depth_q == '0);
  assign top_ptr = depth_q - DEP_W'(1);
  assign dout_o  = empty_o ? '0 : mem_q[top_ptr[IDX_W-1:0]];
  assign depth_o = depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[depth_q[IDX_W-1:0]] <= din_i;
      depth_q <= depth_q + DEP_W'(1);
    end else if (pop_i && !empty_o) begin
      depth_q <= depth_q - DEP_W'(1);
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= DEP_W'(DEPTH)) else $error("stack depth out of range"); // R9
  AST_PUSH_POP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)) else $error("push and pop together"); // R11
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned N_SRC    = DEF_N_SRC,
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned PC_W     = DEF_PC_W,
  parameter logic [31:0] VEC_BASE = DEF_VEC_BASE,
  parameter int unsigned SRC_W    = $clog2(N_SRC),
  parameter int unsigned LVL_W    = $clog2(N_SRC + 1),
  parameter int unsigned DEP_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             boundary_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             rte_i,
  input  logic             set_level_i,
  input  logic [LVL_W-1:0] level_wr_i,
  input  logic             set_ie_i,
  input  logic             ie_wr_i,
  output logic             take_o,
  output logic [SRC_W-1:0] src_o,
  output logic [PC_W-1:0]  vec_o,
  output logic [PC_W-1:0]  epc_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ie_o,
  output logic             sup_o,
  output logic [DEP_W-1:0] depth_o,
  output logic             ovf_o
);
  localparam int unsigned ENT_W = PC_W + LVL_W + 1;

  mode_e            mode_q;
  logic             ie_q, ovf_q;
  logic [LVL_W-1:0] lvl_q;
  logic             pick_vld;
  logic [SRC_W-1:0] pick_idx;
  logic             want, take, do_ret, full, empty;
  logic [ENT_W-1:0] push_ent, top_ent;
  logic [PC_W-1:0]  top_pc;
  logic [LVL_W-1:0] top_lvl;
  mode_e            top_mode;

  irq_prio_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_pick (
    .req_i  (irq_i),
    .level_i(lvl_q),
    .valid_o(pick_vld),
    .idx_o  (pick_idx)
  );

  // return wins over a same-cycle entry
  assign want   = boundary_i && ie_q && pick_vld && !rte_i;
  assign take   = want && !full;
  assign do_ret = rte_i && !empty;

  assign push_ent = {pc_i, lvl_q, mode_q};

  irq_nest_stack #(.W(ENT_W), .DEPTH(DEPTH), .DEP_W(DEP_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (take),
    .pop_i  (do_ret),
    .din_i  (push_ent),
    .dout_o (top_ent),
    .depth_o(depth_o),
    .full_o (full),
    .empty_o(empty)
  );

  assign top_pc   = top_ent[ENT_W-1 -: PC_W];
  assign top_lvl  = top_ent[LVL_W:1];
  assign top_mode = mode_e'(top_ent[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_USER;
      ie_q   <= 1'b1;
      lvl_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (take) begin
        mode_q <= MODE_SUP;
        ie_q   <= 1'b0;
      end else if (do_ret) begin
        mode_q <= top_mode;
        lvl_q  <= top_lvl;
        ie_q   <= 1'b1;
      end else if (mode_q == MODE_SUP) begin
        if (set_level_i) lvl_q <= level_wr_i;
        if (set_ie_i)    ie_q  <= ie_wr_i;
      end
      if (want && full) ovf_q <= 1'b1;
    end
  end

  assign take_o  = take;
  assign src_o   = pick_idx;
  assign vec_o   = PC_W'(VEC_BASE) + (PC_W'(pick_idx) << 2);
  assign epc_o   = top_pc;
  assign level_o = lvl_q;
  assign ie_o    = ie_q;
  assign sup_o   = (mode_q == MODE_SUP);
  assign ovf_o   = ovf_q;

  AST_ENTRY_SUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (mode_q == MODE_SUP) && !ie_q) else $error("entry state"); // R5
  AST_PICK_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> irq_i[pick_idx] && (LVL_W'(pick_idx) >= lvl_q)) else $error("ineligible pick"); // R6
  AST_PICK_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> ((irq_i >> pick_idx) >> 1) == '0) else $error("not highest"); // R3
  AST_RET_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_ret |=> ie_q) else $error("return enable"); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q) else $error("overflow dropped"); // R9
  AST_USER_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_USER) && !take && !do_ret |=> $stable(lvl_q) && $stable(ie_q))
    else $error("user write honored"); // R10
endmodule

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_i = '0;
  logic        boundary_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        rte_i = 1'b0;
  logic        set_level_i = 1'b0;
  logic [3:0]  level_wr_i = '0;
  logic        set_ie_i = 1'b0;
  logic        ie_wr_i = 1'b0;
  logic        take_o;
  logic [2:0]  src_o;
  logic [31:0] vec_o, epc_o;
  logic [3:0]  level_o;
  logic        ie_o, sup_o, ovf_o;
  logic [2:0]  depth_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_entry_ctrl u0 (.*);

  // {irq[7:0], take, src[2:0]} at level 0, enabled, empty stack
  localparam logic [11:0] TBL [7] = '{
    {8'h00, 1'b0, 3'd0}, {8'h01, 1'b1, 3'd0}, {8'h80, 1'b1, 3'd7},
    {8'h12, 1'b1, 3'd4}, {8'hFF, 1'b1, 3'd7}, {8'h06, 1'b1, 3'd2},
    {8'h28, 1'b1, 3'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    boundary_i = 0; rte_i = 0; set_level_i = 0; set_ie_i = 0;
  endtask

  task automatic sw_write(input logic [3:0] lv, input logic en);
    set_level_i = 1; level_wr_i = lv; set_ie_i = 1; ie_wr_i = en;
    cyc(); idle();
  endtask

  task automatic state(input string req, input logic s, input logic e,
                       input logic [3:0] l, input logic [2:0] d);
    chk({req, " sup"}, 32'(sup_o), 32'(s));
    chk({req, " ie"}, 32'(ie_o), 32'(e));
    chk({req, " level"}, 32'(level_o), 32'(l));
    chk({req, " depth"}, 32'(depth_o), 32'(d));
  endtask

  task automatic enter(input string req, input logic [7:0] irq, input logic [31:0] pc,
                       input logic [2:0] src);
    irq_i = irq; pc_i = pc; boundary_i = 1; #1;
    chk({req, " take"}, 32'(take_o), 32'd1);
    chk({req, " src"}, 32'(src_o), 32'(src));
    chk("R4 vec", vec_o, 32'h100 + 32'(src) * 4);
    cyc(); idle();
  endtask

  task automatic ret(input string req, input logic [31:0] pc);
    rte_i = 1; #1;
    chk({req, " epc"}, epc_o, pc);
    cyc(); idle();
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #5 rst_ni = 1;
    cyc();
    state("R1 reset", 0, 1, 0, 0);
    chk("R1 ovf", 32'(ovf_o), 0);
    chk("R1 take", 32'(take_o), 0);

    foreach (TBL[k]) begin
      irq_i = TBL[k][11:4]; boundary_i = 1; #1;
      chk("R2 table take", 32'(take_o), 32'(TBL[k][3]));
      if (TBL[k][3]) begin
        chk("R3 table src", 32'(src_o), 32'(TBL[k][2:0]));
        chk("R4 table vec", vec_o, 32'h100 + 32'(TBL[k][2:0]) * 4);
      end
      boundary_i = 0;
      cyc();
    end

    irq_i = 8'h04; #1;
    chk("R12 no boundary", 32'(take_o), 0);
    cyc();
    state("R12 no change", 0, 1, 0, 0);

    enter("R5 first", 8'h04, 32'h1000, 3'd2);
    state("R5 after", 1, 0, 0, 1);
    chk("R5 epc", epc_o, 32'h1000);

    irq_i = 8'h80; boundary_i = 1; #1;
    chk("R2 ie off", 32'(take_o), 0);
    cyc(); idle();

    sw_write(4'd3, 1'b1);
    state("R10 sup write", 1, 1, 3, 1);

    irq_i = 8'h04; boundary_i = 1; #1;
    chk("R6 masked", 32'(take_o), 0);
    cyc(); idle();

    enter("R7 preempt", 8'h24, 32'h2000, 3'd5);
    state("R7 nested", 1, 0, 3, 2);
    chk("R7 epc", epc_o, 32'h2000);

    sw_write(4'd8, 1'b1);
    irq_i = 8'hFF; boundary_i = 1; #1;
    chk("R6 level 8", 32'(take_o), 0);
    cyc(); idle();
    sw_write(4'd6, 1'b1);

    irq_i = 8'hA4; boundary_i = 1; rte_i = 1; #1;
    chk("R11 rte wins", 32'(take_o), 0);
    chk("R11 epc", epc_o, 32'h2000);
    cyc(); idle();
    state("R11 popped", 1, 1, 3, 1);
    chk("R11 epc below", epc_o, 32'h1000);

    set_level_i = 1; level_wr_i = 4'd1; set_ie_i = 1; ie_wr_i = 1;
    enter("R11 entry over write", 8'hA4, 32'h3000, 3'd7);
    state("R11 write lost", 1, 0, 3, 2);

    sw_write(4'd0, 1'b1);
    enter("R7 third", 8'h80, 32'h4000, 3'd7);
    sw_write(4'd0, 1'b1);
    enter("R7 fourth", 8'h80, 32'h5000, 3'd7);
    sw_write(4'd0, 1'b1);
    state("R9 full", 1, 1, 0, 4);

    irq_i = 8'h80; pc_i = 32'h6000; boundary_i = 1; #1;
    chk("R9 no take", 32'(take_o), 0);
    cyc(); idle();
    state("R9 unchanged", 1, 1, 0, 4);
    chk("R9 ovf", 32'(ovf_o), 1);
    chk("R9 epc", epc_o, 32'h5000);

    ret("R8 ret1", 32'h5000);
    state("R8 ret1", 1, 1, 0, 3);
    ret("R8 ret2", 32'h4000);
    ret("R8 ret3", 32'h3000);
    state("R8 ret3", 1, 1, 3, 1);
    ret("R8 ret4", 32'h1000);
    state("R8 user", 0, 1, 0, 0);
    chk("R9 ovf sticky", 32'(ovf_o), 1);

    rte_i = 1; cyc(); idle();
    state("R8 empty ret", 0, 1, 0, 0);

    sw_write(4'd5, 1'b0);
    state("R10 user write", 0, 1, 0, 0);

    enter("R13 held line", 8'h04, 32'h7000, 3'd2);
    state("R13 reentered", 1, 0, 0, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule